// File: doc/BRIEF.md
# Memory-Driven JTAG Stream Player

This block replays a scan-chain programming sequence that was prepared offline and stored in a byte-wide nonvolatile memory. It does not implement a TAP state machine. It copies stored bits onto TCK, TMS and TDI exactly as they were laid down, so any chain of 1149.1 devices can be loaded by one small piece of logic on the board.

After every reset, power-on included, the player stays quiet for a configurable warm-up interval so the target chain can settle. It then claims the board:

- it pulls the target reset low;
- it enables the memory;
- it lights an active-low status lamp.

It reads a four-byte little-endian length word that holds the end address, then walks the stream from address 4. Every stream byte yields four TCK pulses. When the end address is reached it hands the board back, raises a sticky done flag and waits for the next reset.

Top module: `jtag_stream_player`

## Requirements
- R1: While reset is asserted, and for exactly DELAY_CYC clock cycles after it is released, tck is 0 and targetRstN, memEnN and ledN are all 1, with done 0.
- R2: On the cycle that ends the warm-up interval, targetRstN, memEnN and ledN fall to 0 together. They stay 0 until the stream ends.
- R3: Memory bytes at addresses 0, 1, 2, 3 form a 32-bit end value, least significant byte at address 0. Memory returns the byte for the address on memAddr one clock after memEnN is low with that address.
- R4: The bytes from address 4 up to end value minus one are replayed in ascending order, four TCK pulses each. An end value of 4 or less gives no pulse at all.
- R5: Within a byte, pulse k (k = 0..3) carries bit 2k on tdi and bit 2k+1 on tms, without inversion. Both are set before tck rises and are held while tck is high.
- R6: tck idles at 0. Each high phase lasts exactly HALF_CYC clocks, and each low phase between pulses lasts at least HALF_CYC clocks.
- R7: After the last byte, targetRstN, memEnN and ledN return to 1 and done rises. From then on done stays 1 and no further tck pulse occurs until reset.
- R8: A reset in the middle of a stream aborts it and restarts the whole sequence (warm-up, header, full stream).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; every release starts a download |
| memAddr | output | 32 | Registered byte address to the stream memory |
| memEnN | output | 1 | Active-low memory enable |
| memRdData | input | 8 | Read data, valid one clock after the address |
| tck | output | 1 | Scan-chain test clock |
| tms | output | 1 | Scan-chain mode select |
| tdi | output | 1 | Serial data into the chain |
| targetRstN | output | 1 | Active-low hold on the target board |
| ledN | output | 1 | Active-low busy lamp |
| done | output | 1 | Sticky completion flag |

## Verification
End values from 0 to 12 are swept, so the empty, single-byte and multi-byte cases are each tried.

Stream contents rotate between four patterns, and each pattern catches a different class of error:

- all zeros and all ones expose stuck or inverted pins;
- alternating 0xAA/0x55 separates a TDI/TMS swap from a wrong pair order;
- an arithmetic pattern catches a skipped or repeated byte.

An end value of 256 places the only nonzero header byte at address 1. A wrong byte order would then give a huge or empty stream instead of 252 bytes.

A reset in the middle of a stream shows that the abort returns the pins to idle and that the replay that follows is complete.

// File: rtl/jsp_pkg.sv
package jsp_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 8;
  localparam int HDR_BYTES = ADDR_W / DATA_W;
  localparam int PAIRS = DATA_W / 2;

  typedef enum logic [2:0] {
    sDelay, sHdrWait, sHdrCap, sCheck, sFetchWait, sFetchCap, sLow, sHigh
  } jsp_state_t;

  typedef struct packed {
    logic       start;
    logic       finish;
    logic       hdrLoad;
    logic [1:0] hdrIdx;
    logic       byteLoad;
    logic       pairNext;
    logic       tckRise;
    logic       tckFall;
    logic       addrInc;
  } jsp_strobe_t;
endpackage

// File: rtl/jsp_ctrl.sv
module jsp_ctrl
  import jsp_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 62_500_000,
  parameter int unsigned HALF_CYC  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        moreData,
  output jsp_strobe_t strobe
);
  localparam int unsigned CNT_MAX = (DELAY_CYC > HALF_CYC) ? DELAY_CYC : HALF_CYC;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DLY_LAST  = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYC - 1);

  jsp_state_t       state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [1:0]       hdrIdx, hdrIdxNxt;
  logic [1:0]       pairIdx, pairIdxNxt;
  logic             finished, finishedNxt;

  always_comb begin
    stateNxt    = state;
    cntNxt      = cnt;
    hdrIdxNxt   = hdrIdx;
    pairIdxNxt  = pairIdx;
    finishedNxt = finished;
    strobe      = '0;
    case (state)
      sDelay: begin
        if (cnt == DLY_LAST) begin
          strobe.start = 1'b1;
          cntNxt       = '0;
          stateNxt     = sHdrWait;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      sHdrWait: stateNxt = sHdrCap;
      sHdrCap: begin
        strobe.hdrLoad = 1'b1;
        strobe.hdrIdx  = hdrIdx;
        strobe.addrInc = 1'b1;
        hdrIdxNxt      = hdrIdx + 1'b1;
        stateNxt       = (hdrIdx == 2'(HDR_BYTES - 1)) ? sCheck : sHdrWait;
      end
      sCheck: begin
        if (finished) begin
          stateNxt = sCheck;
        end else if (moreData) begin
          stateNxt = sFetchWait;
        end else begin
          strobe.finish = 1'b1;
          finishedNxt   = 1'b1;
        end
      end
      sFetchWait: stateNxt = sFetchCap;
      sFetchCap: begin
        strobe.byteLoad = 1'b1;
        cntNxt          = '0;
        pairIdxNxt      = '0;
        stateNxt        = sLow;
      end
      sLow: begin
        if (cnt == HALF_LAST) begin
          strobe.tckRise = 1'b1;
          cntNxt         = '0;
          stateNxt       = sHigh;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      sHigh: begin
        if (cnt == HALF_LAST) begin
          strobe.tckFall = 1'b1;
          cntNxt         = '0;
          if (pairIdx == 2'(PAIRS - 1)) begin
            strobe.addrInc = 1'b1;
            stateNxt       = sCheck;
          end else begin
            strobe.pairNext = 1'b1;
            pairIdxNxt      = pairIdx + 1'b1;
            stateNxt        = sLow;
          end
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      default: stateNxt = sDelay;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= sDelay;
      cnt      <= '0;
      hdrIdx   <= '0;
      pairIdx  <= '0;
      finished <= 1'b0;
    end else begin
      state    <= stateNxt;
      cnt      <= cntNxt;
      hdrIdx   <= hdrIdxNxt;
      pairIdx  <= pairIdxNxt;
      finished <= finishedNxt;
    end
  end

  AST_FETCH_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.byteLoad |-> moreData); // R4
  AST_NO_FETCH_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    finished |-> !strobe.byteLoad && !strobe.tckRise); // R7
endmodule

// File: rtl/jsp_datapath.sv
module jsp_datapath
  import jsp_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  jsp_strobe_t       strobe,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              moreData,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              targetRstN,
  output logic              memEnN,
  output logic              ledN,
  output logic              done
);
  localparam int HL_W = $clog2(HALF_CYC + 2);

  logic [ADDR_W-1:0] endVal;
  logic [DATA_W-1:0] byteReg;

  assign moreData = memAddr < endVal;
  assign tdi      = byteReg[0];
  assign tms      = byteReg[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      endVal  <= '0;
      byteReg <= '0;
    end else begin
      if (strobe.addrInc) memAddr <= memAddr + 1'b1;
      if (strobe.hdrLoad) endVal[DATA_W*strobe.hdrIdx +: DATA_W] <= memRdData;
      if (strobe.byteLoad)      byteReg <= memRdData;
      else if (strobe.pairNext) byteReg <= byteReg >> 2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tck        <= 1'b0;
      targetRstN <= 1'b1;
      memEnN     <= 1'b1;
      ledN       <= 1'b1;
      done       <= 1'b0;
    end else begin
      if (strobe.tckRise)      tck <= 1'b1;
      else if (strobe.tckFall) tck <= 1'b0;
      if (strobe.start) begin
        targetRstN <= 1'b0;
        memEnN     <= 1'b0;
        ledN       <= 1'b0;
      end
      if (strobe.finish) begin
        targetRstN <= 1'b1;
        memEnN     <= 1'b1;
        ledN       <= 1'b1;
        done       <= 1'b1;
      end
    end
  end

  // Length of the current tck high phase, kept for the width check
  logic [HL_W-1:0] highLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    highLen <= '0;
    else if (tck) highLen <= highLen + 1'b1;
    else          highLen <= '0;
  end

  AST_TCK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tck) |-> $past(highLen) == HL_W'(HALF_CYC - 1)); // R6
  AST_PINS_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    tck |-> $stable(tdi) && $stable(tms)); // R5
  AST_RISE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tck) |-> moreData); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done); // R7
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> targetRstN && memEnN && ledN && !tck); // R7
  AST_CLAIM_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memEnN) |-> !targetRstN && !ledN); // R2
endmodule

// File: rtl/jtag_stream_player.sv
module jtag_stream_player
  import jsp_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 62_500_000,
  parameter int unsigned HALF_CYC  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  output logic [31:0] memAddr,
  output logic        memEnN,
  input  logic [7:0]  memRdData,
  output logic        tck,
  output logic        tms,
  output logic        tdi,
  output logic        targetRstN,
  output logic        ledN,
  output logic        done
);
  jsp_strobe_t strobe;
  logic        moreData;

  jsp_ctrl #(.DELAY_CYC(DELAY_CYC), .HALF_CYC(HALF_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .moreData(moreData), .strobe(strobe)
  );

  jsp_datapath #(.HALF_CYC(HALF_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdData(memRdData),
    .memAddr(memAddr), .moreData(moreData), .tck(tck), .tms(tms), .tdi(tdi),
    .targetRstN(targetRstN), .memEnN(memEnN), .ledN(ledN), .done(done)
  );
endmodule

// File: tb/jtag_stream_player_tb_top.sv
module jtag_stream_player_tb_top;
  localparam int DLY  = 5;
  localparam int HALF = 2;
  localparam int MEMN = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] memAddr;
  logic        memEnN, tck, tms, tdi, targetRstN, ledN, done;
  logic [7:0]  memRd;
  logic [7:0]  mem [0:MEMN-1];

  jtag_stream_player #(.DELAY_CYC(DLY), .HALF_CYC(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memEnN(memEnN),
    .memRdData(memRd), .tck(tck), .tms(tms), .tdi(tdi),
    .targetRstN(targetRstN), .ledN(ledN), .done(done)
  );

  // Synchronous memory: one clock of read latency (R3)
  always @(posedge clk) if (!memEnN) memRd <= mem[memAddr[8:0]];

  int errs = 0;
  int checks = 0;
  int curEnd = 0;
  int pulseIdx = 0, highLen = 0, lowLen = 0;
  logic prevTck = 1'b0, hTdi = 1'b0, hTms = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Pin monitor: samples away from the active edge
  always @(negedge clk) begin
    int a, k;
    if (!rstN) begin
      pulseIdx = 0; highLen = 0; lowLen = 0; prevTck = 1'b0;
    end else begin
      if (tck && !prevTck) begin
        a = 4 + pulseIdx / 4;
        k = pulseIdx % 4;
        if (a >= curEnd) chk(1'b0, "R4", "pulse beyond stream end", pulseIdx + 1, (curEnd > 4) ? 4 * (curEnd - 4) : 0);
        else begin
          chk(tdi == mem[a][2*k],   "R5", "tdi bit", tdi, mem[a][2*k]);
          chk(tms == mem[a][2*k+1], "R5", "tms bit", tms, mem[a][2*k+1]);
        end
        if (pulseIdx > 0) chk(lowLen >= HALF, "R6", "tck low length", lowLen, HALF);
        hTdi = tdi; hTms = tms; highLen = 1; pulseIdx++;
      end else if (tck) begin
        highLen++;
        chk({tdi, tms} == {hTdi, hTms}, "R5", "pins held while tck high", {tdi, tms}, {hTdi, hTms});
      end else if (prevTck) begin
        chk(highLen == HALF, "R6", "tck high length", highLen, HALF);
        lowLen = 1;
      end else begin
        lowLen++;
      end
      prevTck = tck;
    end
  end

  task automatic fill(input int endV, input int mode);
    for (int i = 4; i < MEMN; i++) begin
      case (mode)
        0: mem[i] = 8'h00;
        1: mem[i] = 8'hFF;
        2: mem[i] = (i % 2 == 1) ? 8'h55 : 8'hAA;
        default: mem[i] = 8'(i * 37 + mode);
      endcase
    end
    mem[0] = 8'(endV);
    mem[1] = 8'(endV >> 8);
    mem[2] = 8'(endV >> 16);
    mem[3] = 8'(endV >> 24);
  endtask

  task automatic startRun(input int endV, input int mode);
    int n;
    fill(endV, mode);
    curEnd = endV;
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk({tck, targetRstN, memEnN, ledN, done} == 5'b01110, "R1", "idle in reset",
        {tck, targetRstN, memEnN, ledN, done}, 5'b01110);
    rstN = 1'b1;
    n = 0;
    while (memEnN && n < DLY + 10) begin
      @(negedge clk);
      n++;
      if (memEnN)
        chk({tck, targetRstN, ledN} == 3'b011, "R1", "quiet during warm-up",
            {tck, targetRstN, ledN}, 3'b011);
    end
    chk(n == DLY, "R1", "warm-up length", n, DLY);
    chk({targetRstN, ledN} == 2'b00, "R2", "board claimed with memory", {targetRstN, ledN}, 2'b00);
  endtask

  task automatic finishRun(input int endV);
    int w, expP, p0;
    expP = (endV > 4) ? 4 * (endV - 4) : 0;
    w = 0;
    while (!done && w < 40000) begin
      @(negedge clk);
      w++;
      if (!done && w > 1)
        chk({targetRstN, memEnN, ledN} == 3'b000, "R2", "held during stream",
            {targetRstN, memEnN, ledN}, 3'b000);
    end
    chk(done, "R7", "done reached", done, 1);
    chk(pulseIdx == expP, "R4", "pulse count", pulseIdx, expP);
    chk({targetRstN, memEnN, ledN} == 3'b111, "R7", "board released",
        {targetRstN, memEnN, ledN}, 3'b111);
    p0 = pulseIdx;
    repeat (20) @(negedge clk);
    chk(done && !tck && pulseIdx == p0, "R7", "quiet and done after end", pulseIdx, p0);
  endtask

  initial begin
    for (int e = 0; e <= 12; e++) begin
      startRun(e, e % 4);
      finishRun(e);
    end
    // R3: the only nonzero header byte is at address 1, so end value = 256
    startRun(256, 3);
    finishRun(256);
    chk(pulseIdx == 1008, "R3", "little-endian header length", pulseIdx, 1008);
    // R8: abort in mid-stream, then replay again
    startRun(40, 2);
    repeat (60) @(negedge clk);
    chk(pulseIdx > 0 && !done, "R8", "stream in progress before abort", pulseIdx, 1);
    startRun(40, 3);
    finishRun(40);
    chk(pulseIdx == 144, "R8", "full replay after restart", pulseIdx, 144);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule